// File: doc/BRIEF.md
# Power Domain State Controller

This block governs a single switchable power domain. Software writes a target power state into a control word. The block then steps the domain through a timed sequence that drives a power-switch enable, an isolation clamp and a retention supply request. A status word reports the settled state and a busy flag, which software polls until the change is done. Each state is a 2-bit code: 0 is off, 1 is retention, 2 is on-but-idle and 3 is fully active. A 4-bit capability parameter, indexed by that code, lists the states the domain supports. A request for a state that the domain lacks is moved up to the nearest supported state above it.

The sequence takes a fixed number of cycles in each direction. When a powered domain drops to an unpowered state, isolation is raised one cycle before the switch opens. When an unpowered domain is powered up, isolation is held for one cycle after the power-up wait ends. A write that lands during a transition is held in a single pending slot, and the newest write wins. That request is taken only after the running sequence completes. A downward request is acted on only if the write also sets the low-power change enable bit.

Top module: `pwr_dom_ctrl`

## Requirements
- R1: After reset the domain is settled in state 3 (the nearest supported state at or above 3). The status busy flag is 0, the control target field reads 3, and the outputs are pwr_en_o=1, iso_o=0 and ret_o=0.
- R2: The control word is at byte offset 0x0. Bits [1:0] hold the target state, bit 2 is logic-retain and bit 4 is the low-power change enable, and all of these read back. The status word is at offset 0x4. Bits [1:0] give the settled state and bit 20 is busy. All other bits read as 0, any other offset reads as 0, and writes to the status word have no effect.
- R3: A requested state whose capability bit is clear is stored, and acted on, as the lowest supported state above it. With the default mask 4'b1011, a request for 2 becomes 3.
- R4: A transition keeps busy set for DN_CYC cycles when going down and UP_CYC cycles when going up. It adds one cycle when a powered state (2 or 3) goes to an unpowered one (0 or 1), and one cycle when an unpowered state goes to a powered one. The settled state changes only in the cycle busy clears.
- R5: Busy is set in the cycle after the clock edge that accepts the write.
- R6: iso_o is high in the cycle before pwr_en_o falls, and iso_o is high whenever pwr_en_o is low.
- R7: iso_o falls only after pwr_en_o has been high for the two preceding cycles. On power-up it releases one cycle after the power-up wait ends.
- R8: A downward request written with bit 4 clear starts no transition and leaves the settled state unchanged.
- R9: A request equal to the settled state starts no transition.
- R10: A control write made while busy is held, with the newest write winning. It starts in the cycle after the running transition completes, including when the write lands on the completing edge.
- R11: ret_o is high only while the domain is settled in retention and the request that entered retention had bit 2 set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe |
| addr_i | input | AW | Byte address for reads and writes |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| pwr_en_o | output | 1 | Power switch enable |
| iso_o | output | 1 | Isolation clamp enable |
| ret_o | output | 1 | Retention supply request |

## Verification
The two functions that can fall in the same cycle are the completion of a running transition and the capture of a new control write into the pending slot. The bench provokes this by counting the busy cycles of a known ACTIVE-to-OFF sequence. It then times a second write so that it is sampled on exactly the edge where the sequencer returns to idle. It judges the result by reading, one cycle later, that the first target has settled with busy clear, and then by seeing the second transition run its full, expected length.

// File: rtl/pwr_dom_pkg.sv
package pwr_dom_pkg;

  typedef enum logic [1:0] {
    PS_OFF     = 2'd0,
    PS_RET     = 2'd1,
    PS_IDLE_ON = 2'd2,
    PS_ACTIVE  = 2'd3
  } pstate_e;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_ISO,
    SQ_WAIT,
    SQ_SETTLE
  } seq_e;

  localparam int unsigned CTRL_OFS = 0;
  localparam int unsigned STAT_OFS = 4;
  localparam int unsigned BIT_LRET = 2;
  localparam int unsigned BIT_LPC  = 4;
  localparam int unsigned BIT_BUSY = 20;

  // lowest supported state at or above req; highest supported otherwise
  function automatic pstate_e resolve_state(logic [1:0] req, logic [3:0] mask);
    pstate_e r;
    logic    found;
    r     = PS_ACTIVE;
    found = 1'b0;
    for (int i = 0; i < 4; i++) begin
      if (!found && mask[i] && i >= int'(req)) begin
        r     = pstate_e'(2'(i));
        found = 1'b1;
      end
    end
    if (!found) begin
      for (int i = 0; i < 4; i++) begin
        if (mask[i]) r = pstate_e'(2'(i));
      end
    end
    return r;
  endfunction

  function automatic logic is_powered(pstate_e s);
    return (s == PS_IDLE_ON) || (s == PS_ACTIVE);
  endfunction

endpackage

// File: rtl/pwr_dom_regs.sv
module pwr_dom_regs
  import pwr_dom_pkg::*;
#(
  parameter int unsigned AW        = 4,
  parameter logic [3:0]  CAP_MASK  = 4'b1011,
  parameter pstate_e     RST_STATE = PS_ACTIVE
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [31:0]   wdata_i,
  input  logic          take_i,
  input  logic          busy_i,
  input  pstate_e       cur_i,
  output logic [31:0]   rdata_o,
  output pstate_e       tgt_o,
  output logic          lret_o,
  output logic          lpc_o,
  output logic          pend_o
);

  localparam logic [AW-1:0] A_CTRL = AW'(CTRL_OFS);
  localparam logic [AW-1:0] A_STAT = AW'(STAT_OFS);

  logic    wr_ctrl;
  pstate_e tgt_q;
  logic    lret_q, lpc_q, pend_q;
  logic    unused_wdata;

  assign wr_ctrl      = wr_i && (addr_i == A_CTRL);
  assign unused_wdata = ^{wdata_i[31:5], wdata_i[3]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgt_q  <= RST_STATE;
      lret_q <= 1'b0;
      lpc_q  <= 1'b0;
      pend_q <= 1'b0;
    end else if (wr_ctrl) begin
      tgt_q  <= resolve_state(wdata_i[1:0], CAP_MASK);
      lret_q <= wdata_i[BIT_LRET];
      lpc_q  <= wdata_i[BIT_LPC];
      pend_q <= 1'b1;
    end else if (take_i) begin
      pend_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_CTRL) begin
      rdata_o[1:0]     = tgt_q;
      rdata_o[BIT_LRET] = lret_q;
      rdata_o[BIT_LPC]  = lpc_q;
    end else if (addr_i == A_STAT) begin
      rdata_o[1:0]      = cur_i;
      rdata_o[BIT_BUSY] = busy_i;
    end
  end

  assign tgt_o  = tgt_q;
  assign lret_o = lret_q;
  assign lpc_o  = lpc_q;
  assign pend_o = pend_q;

endmodule

// File: rtl/pwr_dom_timer.sv
module pwr_dom_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             done_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/pwr_dom_seq.sv
module pwr_dom_seq
  import pwr_dom_pkg::*;
#(
  parameter int unsigned UP_CYC    = 6,
  parameter int unsigned DN_CYC    = 4,
  parameter pstate_e     RST_STATE = PS_ACTIVE
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    pend_i,
  input  pstate_e tgt_i,
  input  logic    lret_i,
  input  logic    lpc_i,
  output logic    take_o,
  output pstate_e cur_o,
  output logic    busy_o,
  output logic    pwr_en_o,
  output logic    iso_o,
  output logic    ret_o
);

  localparam int unsigned MAX_CYC = (UP_CYC > DN_CYC) ? UP_CYC : DN_CYC;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  seq_e    sq_q;
  pstate_e cur_q, dst_q;
  logic    dn_q, lret_q;
  logic    go, down, iso_lead, tmr_load, tmr_done;
  logic [CNT_W-1:0] tmr_val;

  assign take_o   = (sq_q == SQ_IDLE) && pend_i;
  assign down     = tgt_i < cur_q;
  assign go       = take_o && (tgt_i != cur_q) && !(down && !lpc_i);
  assign iso_lead = down && is_powered(cur_q) && !is_powered(tgt_i);

  // timer loads on entry to the wait phase
  assign tmr_load = (go && !iso_lead) || (sq_q == SQ_ISO);
  assign tmr_val  = ((sq_q == SQ_ISO) || down) ? CNT_W'(DN_CYC - 1) : CNT_W'(UP_CYC - 1);

  pwr_dom_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .done_o     (tmr_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sq_q   <= SQ_IDLE;
      cur_q  <= RST_STATE;
      dst_q  <= RST_STATE;
      dn_q   <= 1'b0;
      lret_q <= 1'b0;
    end else begin
      case (sq_q)
        SQ_IDLE: if (go) begin
          dst_q  <= tgt_i;
          dn_q   <= down;
          lret_q <= lret_i;
          sq_q   <= iso_lead ? SQ_ISO : SQ_WAIT;
        end
        SQ_ISO: sq_q <= SQ_WAIT;
        SQ_WAIT: if (tmr_done) begin
          if (!dn_q && !is_powered(cur_q) && is_powered(dst_q)) begin
            sq_q <= SQ_SETTLE;
          end else begin
            sq_q  <= SQ_IDLE;
            cur_q <= dst_q;
          end
        end
        default: begin
          sq_q  <= SQ_IDLE;
          cur_q <= dst_q;
        end
      endcase
    end
  end

  always_comb begin
    case (sq_q)
      SQ_IDLE: begin
        pwr_en_o = is_powered(cur_q);
        iso_o    = !is_powered(cur_q);
      end
      SQ_ISO: begin
        pwr_en_o = 1'b1;
        iso_o    = 1'b1;
      end
      SQ_WAIT: begin
        pwr_en_o = is_powered(dst_q);
        iso_o    = !(is_powered(dst_q) && is_powered(cur_q));
      end
      default: begin
        pwr_en_o = 1'b1;
        iso_o    = 1'b1;
      end
    endcase
  end

  assign busy_o = (sq_q != SQ_IDLE);
  assign ret_o  = (sq_q == SQ_IDLE) && (cur_q == PS_RET) && lret_q;
  assign cur_o  = cur_q;

endmodule

// File: rtl/pwr_dom_ctrl.sv
module pwr_dom_ctrl
  import pwr_dom_pkg::*;
#(
  parameter int unsigned AW       = 4,
  parameter logic [3:0]  CAP_MASK = 4'b1011,
  parameter int unsigned UP_CYC   = 6,
  parameter int unsigned DN_CYC   = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o,
  output logic          pwr_en_o,
  output logic          iso_o,
  output logic          ret_o
);

  localparam pstate_e RST_STATE = resolve_state(2'd3, CAP_MASK);

  pstate_e tgt, cur_state;
  logic    lret, lpc, pend, take, busy;

  pwr_dom_regs #(
    .AW        (AW),
    .CAP_MASK  (CAP_MASK),
    .RST_STATE (RST_STATE)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .take_i  (take),
    .busy_i  (busy),
    .cur_i   (cur_state),
    .rdata_o (rdata_o),
    .tgt_o   (tgt),
    .lret_o  (lret),
    .lpc_o   (lpc),
    .pend_o  (pend)
  );

  pwr_dom_seq #(
    .UP_CYC    (UP_CYC),
    .DN_CYC    (DN_CYC),
    .RST_STATE (RST_STATE)
  ) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pend_i   (pend),
    .tgt_i    (tgt),
    .lret_i   (lret),
    .lpc_i    (lpc),
    .take_o   (take),
    .cur_o    (cur_state),
    .busy_o   (busy),
    .pwr_en_o (pwr_en_o),
    .iso_o    (iso_o),
    .ret_o    (ret_o)
  );

endmodule

// File: rtl/pwr_dom_ctrl_chk.sv
module pwr_dom_ctrl_chk
  import pwr_dom_pkg::*;
(
  input logic    clk_i,
  input logic    rst_ni,
  input logic    pwr_en_o,
  input logic    iso_o,
  input logic    ret_o,
  input logic    busy,
  input pstate_e cur_state
);

  a_r6_iso_before_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pwr_en_o) |-> $past(iso_o));

  a_r6_off_is_isolated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_en_o |-> iso_o);

  a_r7_release_after_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(iso_o) |-> ($past(pwr_en_o) && $past(pwr_en_o, 2)));

  a_r4_state_held_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && $past(busy)) |-> $stable(cur_state));

  a_r4_state_moves_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cur_state) |-> ($past(busy) && !busy));

  a_r11_ret_only_settled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_o |-> (!busy && cur_state == PS_RET && !pwr_en_o));

endmodule

bind pwr_dom_ctrl pwr_dom_ctrl_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .pwr_en_o  (pwr_en_o),
  .iso_o     (iso_o),
  .ret_o     (ret_o),
  .busy      (busy),
  .cur_state (cur_state)
);

// File: tb/pwr_dom_ctrl_test.sv
`timescale 1ns/1ps
module pwr_dom_ctrl_test;

  localparam int UP = 6;
  localparam int DN = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        pwr_en_o, iso_o, ret_o;

  int checks = 0;
  int failures = 0;

  pwr_dom_ctrl #(.AW(4), .CAP_MASK(4'b1011), .UP_CYC(UP), .DN_CYC(DN)) uut (
    .clk_i, .rst_ni, .wr_i, .addr_i, .wdata_i, .rdata_o, .pwr_en_o, .iso_o, .ret_o
  );

  always #4 clk_i = ~clk_i;

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  function automatic logic [31:0] cw(input int tgt, input bit lret, input bit lpc);
    logic [31:0] w = '0;
    w[1:0] = 2'(tgt);
    w[2]   = lret;
    w[4]   = lpc;
    return w;
  endfunction

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr_i = a;
    #1;
    d = rdata_o;
  endtask

  // counts busy samples of one transition; stops at the first idle sample
  task automatic measure(output int n, output bit first_busy);
    logic [31:0] s;
    n = 0; first_busy = 1'b0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk_i);
      rd(4'h4, s);
      if (i == 0) first_busy = s[20];
      if (s[20]) n++;
      else if (n > 0) break;
    end
  endtask

  task automatic no_busy(input string rq, input int exp_state);
    logic [31:0] s;
    bit seen = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk_i);
      rd(4'h4, s);
      if (s[20]) seen = 1'b1;
    end
    chk(!seen, rq, "busy seen", int'(seen), 0);
    chk(s[1:0] == 2'(exp_state), rq, "state", int'(s[1:0]), exp_state);
  endtask

  task automatic go(input string rq, input logic [31:0] d, input int exp_n, input int exp_state);
    int n; bit fb; logic [31:0] s;
    wr(4'h0, d);
    measure(n, fb);
    chk(n == exp_n, rq, "busy cycles", n, exp_n);
    rd(4'h4, s);
    chk(s[1:0] == 2'(exp_state), rq, "settled state", int'(s[1:0]), exp_state);
  endtask

  task automatic t_reset;
    logic [31:0] s;
    rd(4'h4, s);
    chk(s == 32'h3, "R1", "status word", int'(s), 3);
    rd(4'h0, s);
    chk(s == 32'h3, "R1", "control word", int'(s), 3);
    chk(pwr_en_o && !iso_o && !ret_o, "R1", "pwr/iso/ret", int'({pwr_en_o, iso_o, ret_o}), 4);
  endtask

  task automatic t_map;
    logic [31:0] s;
    rd(4'h8, s);
    chk(s == 0, "R2", "unmapped read", int'(s), 0);
    wr(4'h4, 32'h0010_0000);
    no_busy("R2", 3);
    wr(4'h0, 32'hFFFF_FFEF & cw(3, 1, 0) | 32'hFFFF_FF00 & 32'h0);
    rd(4'h0, s);
    chk(s == 32'h7, "R2", "control readback", int'(s), 7);
  endtask

  task automatic t_same;
    wr(4'h0, cw(3, 0, 1));
    no_busy("R9", 3);
  endtask

  task automatic t_gate;
    logic [31:0] s;
    wr(4'h0, cw(0, 0, 0));
    no_busy("R8", 3);
    chk(pwr_en_o == 1'b1, "R8", "power kept", int'(pwr_en_o), 1);
    rd(4'h0, s);
    chk(s[4:0] == 5'h0, "R2", "control holds request", int'(s[4:0]), 0);
  endtask

  task automatic t_act_off;
    int n; bit fb; logic [31:0] s;
    wr(4'h0, cw(0, 0, 1));
    measure(n, fb);
    chk(fb, "R5", "busy in first cycle", int'(fb), 1);
    chk(n == DN + 1, "R4", "down busy cycles", n, DN + 1);
    rd(4'h4, s);
    chk(s[1:0] == 2'd0, "R4", "state off", int'(s[1:0]), 0);
    chk(!pwr_en_o && iso_o, "R6", "off outputs", int'({pwr_en_o, iso_o}), 1);
  endtask

  task automatic t_off_act;
    go("R4", cw(3, 0, 0), UP + 1, 3);
    chk(pwr_en_o && !iso_o, "R7", "powered outputs", int'({pwr_en_o, iso_o}), 2);
  endtask

  task automatic t_ret;
    logic [31:0] s;
    go("R4", cw(1, 1, 1), DN + 1, 1);
    chk(ret_o == 1'b1, "R11", "ret with logic-retain", int'(ret_o), 1);
    wr(4'h0, cw(2, 0, 0));
    rd(4'h0, s);
    chk(s[1:0] == 2'd3, "R3", "resolved target", int'(s[1:0]), 3);
    begin
      int n; bit fb;
      measure(n, fb);
      chk(n == UP + 1, "R3", "resolved up busy cycles", n, UP + 1);
    end
    rd(4'h4, s);
    chk(s[1:0] == 2'd3, "R3", "resolved state", int'(s[1:0]), 3);
    chk(ret_o == 1'b0, "R11", "ret after leaving", int'(ret_o), 0);
  endtask

  task automatic t_ret_plain;
    go("R4", cw(1, 0, 1), DN + 1, 1);
    chk(ret_o == 1'b0, "R11", "ret without logic-retain", int'(ret_o), 0);
    go("R4", cw(0, 0, 1), DN, 0);
    go("R4", cw(1, 0, 0), UP, 1);
    go("R4", cw(3, 0, 0), UP + 1, 3);
  endtask

  task automatic t_latch;
    logic [31:0] s;
    int n; bit fb;
    wr(4'h0, cw(0, 0, 1));
    @(negedge clk_i);
    wr(4'h0, cw(1, 0, 0));
    wr(4'h0, cw(3, 0, 0));
    for (int i = 0; i < 20; i++) begin
      rd(4'h4, s);
      if (!s[20]) break;
      @(negedge clk_i);
    end
    chk(s[1:0] == 2'd0 && !s[20], "R10", "first target settled", int'(s[1:0]), 0);
    measure(n, fb);
    chk(n == UP + 1, "R10", "latched busy cycles", n, UP + 1);
    rd(4'h4, s);
    chk(s[1:0] == 2'd3, "R10", "newest write wins", int'(s[1:0]), 3);
  endtask

  task automatic t_edge;
    logic [31:0] s;
    int n; bit fb;
    wr(4'h0, cw(0, 0, 1));
    repeat (DN + 1) @(negedge clk_i);
    wr(4'h0, cw(3, 0, 0));
    rd(4'h4, s);
    chk(s[1:0] == 2'd0 && !s[20], "R10", "edge write: prior settled", int'(s), 0);
    measure(n, fb);
    chk(fb && n == UP + 1, "R10", "edge write busy cycles", n, UP + 1);
    rd(4'h4, s);
    chk(s[1:0] == 2'd3, "R10", "edge write final", int'(s[1:0]), 3);
  endtask

  initial begin
    #(8 * 100000);
    failures++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_map();
    t_same();
    t_gate();
    t_act_off();
    t_off_act();
    t_ret();
    t_ret_plain();
    t_latch();
    t_edge();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule